// File: doc/BRIEF.md
# Bus Hold Arbiter with Refresh Reclaim

This block lets an external bus master borrow the local bus from the processor. The master raises an asynchronous, active-high hold request. The block synchronizes it and samples it only when no processor bus cycle is in flight. When it grants the bus, it raises the hold acknowledge and removes the output enables of the address, data and control drivers in the same clock. It keeps the grant for as long as the request stays high. After the request falls, the bus stays floated until the processor needs a cycle again. The drivers come back one cycle before the processor may start that cycle.

A DRAM refresh request from an external timer is latched inside the block. The processor runs the latched refresh as soon as it owns an idle bus, and a pending refresh takes priority over a new hold request. In enhanced mode, a refresh that becomes pending while the bus is granted pulls the acknowledge low although the request is still high. This tells the master to let go. The refresh runs only after the master drops its request. Outside enhanced mode, the refresh simply waits until the bus comes back.

Top module: `bus_hold_arbiter`

## Requirements
- R1: With the bus idle and no refresh pending, a hold request that is set up before clock edge 1 makes hold_ack_o high after edge 3 and not before.
- R2: While cycle_busy_i is high with the bus owned, no grant is made; the grant follows on the first edge where cycle_busy_i is low.
- R3: bus_oe_o falls in the same cycle that hold_ack_o rises, and hold_ack_o is never high while bus_oe_o is high.
- R4: hold_ack_o falls on the third edge after the hold request is removed (two synchronizer edges plus one state edge).
- R5: After release, bus_oe_o stays low until bus_need_i or a pending refresh is seen. bus_oe_o then returns one cycle before bus_avail_o rises.
- R6: With enhanced_i high, a refresh pending during a grant drops hold_ack_o while the hold request is still high, and the bus stays floated.
- R7: refresh_go_o is high only while bus_avail_o is high, so a refresh issues only after the master has released the bus and it has been reclaimed.
- R8: With enhanced_i low, a pending refresh leaves hold_ack_o high for as long as the request stays high. The refresh then runs after the bus returns, without any bus_need_i.
- R9: When the bus is owned and idle, a pending refresh is issued before a hold request is granted. refresh_go_o is a one-cycle pulse and is never high in two consecutive cycles.
- R10: During and right after reset, hold_ack_o=0, bus_oe_o=1, bus_avail_o=1 and refresh_go_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enhanced_i | input | 1 | 1 selects early acknowledge drop on pending refresh |
| hold_req_i | input | 1 | Asynchronous bus request from the external master, active high |
| cycle_busy_i | input | 1 | Processor bus cycle or locked sequence in progress |
| bus_need_i | input | 1 | Processor wants to run a bus cycle |
| refresh_req_i | input | 1 | One-cycle refresh request from the refresh timer |
| hold_ack_o | output | 1 | Bus grant acknowledge to the external master |
| bus_oe_o | output | 1 | Output enable for address, data and control drivers |
| bus_avail_o | output | 1 | Processor may start a bus cycle |
| refresh_go_o | output | 1 | One-cycle pulse that starts a refresh cycle |

## Verification
A wrong arbitration state shows at the ports within one clock. Acknowledge and the output enables would both be asserted, or the bus would float while nobody holds the acknowledge. An early reclaim would make bus_avail_o rise in the same cycle as bus_oe_o. A miscounted synchronizer moves the rise and fall of hold_ack_o by whole cycles against the three-edge latency. A lost or doubled refresh shows as a missing or repeated refresh_go_o pulse a few cycles after the bus returns.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  typedef enum logic [1:0] {
    ST_OWNED   = 2'd0,
    ST_GRANTED = 2'd1,
    ST_RFWAIT  = 2'd2,
    ST_RECLAIM = 2'd3
  } arb_state_e;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[i] <= 1'b0;
        else         chain_q[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[i] <= 1'b0;
        else         chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/refresh_latch.sv
module refresh_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  // a new request wins over the clear of the one being issued
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;

  assign pend_o = pend_q;
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import bus_hold_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enhanced_i,
  input  logic hold_s_i,
  input  logic busy_i,
  input  logic need_i,
  input  logic pend_i,
  output logic issue_o,
  output logic ack_o,
  output logic oe_o,
  output logic avail_o,
  output logic go_o
);
  arb_state_e st_q, st_d;
  logic       ack_q, ack_d;
  logic       go_q;
  logic       issue;

  always_comb begin
    st_d  = st_q;
    ack_d = ack_q;
    issue = 1'b0;
    unique case (st_q)
      ST_OWNED: begin
        ack_d = 1'b0;
        if (!busy_i) begin
          if (pend_i) begin
            issue = ~go_q;
          end else if (hold_s_i) begin
            st_d  = ST_GRANTED;
            ack_d = 1'b1;
          end
        end
      end
      ST_GRANTED: begin
        if (hold_s_i) begin
          if (enhanced_i && pend_i) begin
            st_d  = ST_RFWAIT;
            ack_d = 1'b0;
          end else begin
            ack_d = 1'b1;
          end
        end else begin
          ack_d = 1'b0;
          if (need_i || pend_i) st_d = ST_RECLAIM;
        end
      end
      ST_RFWAIT: begin
        ack_d = 1'b0;
        if (!hold_s_i) st_d = ST_RECLAIM;
      end
      ST_RECLAIM: begin
        ack_d = 1'b0;
        st_d  = ST_OWNED;
      end
      default: begin
        ack_d = 1'b0;
        st_d  = ST_OWNED;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q  <= ST_OWNED;
      ack_q <= 1'b0;
      go_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= ack_d;
      go_q  <= issue;
    end

  assign issue_o = issue;
  assign ack_o   = ack_q;
  assign oe_o    = (st_q == ST_OWNED) || (st_q == ST_RECLAIM);
  assign avail_o = (st_q == ST_OWNED);
  assign go_o    = go_q;
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enhanced_i,
  input  logic hold_req_i,
  input  logic cycle_busy_i,
  input  logic bus_need_i,
  input  logic refresh_req_i,
  output logic hold_ack_o,
  output logic bus_oe_o,
  output logic bus_avail_o,
  output logic refresh_go_o
);
  logic hold_s;
  logic pend;
  logic issue;

  hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (hold_req_i),
    .q_o    (hold_s)
  );

  refresh_latch u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (refresh_req_i),
    .clr_i  (issue),
    .pend_o (pend)
  );

  hold_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enhanced_i (enhanced_i),
    .hold_s_i   (hold_s),
    .busy_i     (cycle_busy_i),
    .need_i     (bus_need_i),
    .pend_i     (pend),
    .issue_o    (issue),
    .ack_o      (hold_ack_o),
    .oe_o       (bus_oe_o),
    .avail_o    (bus_avail_o),
    .go_o       (refresh_go_o)
  );
endmodule

// File: rtl/bus_hold_arbiter_chk.sv
module bus_hold_arbiter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cycle_busy_i,
  input logic hold_ack_o,
  input logic bus_oe_o,
  input logic bus_avail_o,
  input logic refresh_go_o
);
  p_ack_float_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_ack_o |-> !bus_oe_o);

  p_grant_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hold_ack_o) && $past(bus_avail_o)) |-> $fell(bus_oe_o));

  p_grant_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hold_ack_o) && $past(bus_avail_o)) |-> !$past(cycle_busy_i));

  p_oe_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_avail_o) |-> $past(bus_oe_o));

  p_avail_driven_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_avail_o |-> bus_oe_o);

  p_go_owned_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_go_o |-> bus_avail_o);

  p_go_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_go_o |=> !refresh_go_o);
endmodule

bind bus_hold_arbiter bus_hold_arbiter_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cycle_busy_i (cycle_busy_i),
  .hold_ack_o   (hold_ack_o),
  .bus_oe_o     (bus_oe_o),
  .bus_avail_o  (bus_avail_o),
  .refresh_go_o (refresh_go_o)
);

// File: tb/bus_hold_arbiter_tb.sv
module bus_hold_arbiter_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enh = 1'b0, hreq = 1'b0, busy = 1'b0, need = 1'b0, rreq = 1'b0;
  logic ack, oe, avail, go;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_hold_arbiter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enhanced_i(enh), .hold_req_i(hreq),
    .cycle_busy_i(busy), .bus_need_i(need), .refresh_req_i(rreq),
    .hold_ack_o(ack), .bus_oe_o(oe), .bus_avail_o(avail), .refresh_go_o(go)
  );

  function automatic void chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endfunction

  // reference model: 0 owned, 1 granted, 2 refresh wait, 3 reclaim
  logic m_s1, m_s2, m_ack, m_pend, m_go;
  int   m_st;
  bit   model_on = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_ack <= 0; m_pend <= 0; m_go <= 0; m_st <= 0;
    end else begin
      int  st_n;
      bit  ack_n, iss;
      st_n = m_st; ack_n = 0; iss = 0;
      case (m_st)
        0: if (!busy) begin
             if (m_pend) iss = !m_go;
             else if (m_s2) begin st_n = 1; ack_n = 1; end
           end
        1: if (m_s2) begin
             if (enh && m_pend) st_n = 2; else ack_n = 1;
           end else if (need || m_pend) st_n = 3;
        2: if (!m_s2) st_n = 3;
        default: st_n = 0;
      endcase
      m_s1 <= hreq; m_s2 <= m_s1; m_st <= st_n; m_ack <= ack_n; m_go <= iss;
      m_pend <= (m_pend & !iss) | rreq;
    end
  end

  always @(negedge clk) if (model_on && rst_n) begin
    chk(ack === m_ack, "R4 ack model", ack, m_ack);
    chk(oe === (m_st == 0 || m_st == 3), "R3 oe model", oe, (m_st == 0 || m_st == 3));
    chk(avail === (m_st == 0), "R5 avail model", avail, (m_st == 0));
    chk(go === m_go, "R7 go model", go, m_go);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int seen_go, go_early;
    void'($urandom(32'h1bad5eed));
    cyc(2);
    chk(ack === 0 && oe === 1 && avail === 1 && go === 0, "R10 in reset", {ack, oe, avail, go}, 4'b0110);
    rst_n = 1'b1;
    cyc(1);
    chk(ack === 0 && oe === 1 && avail === 1 && go === 0, "R10 after reset", {ack, oe, avail, go}, 4'b0110);
    model_on = 1'b1;

    // R1 latency
    hreq = 1; cyc(2);
    chk(ack === 0, "R1 no early ack", ack, 0);
    cyc(1);
    chk(ack === 1, "R1 ack after edge 3", ack, 1);
    chk(oe === 0, "R3 floated with ack", oe, 0);
    // R4 release latency
    hreq = 0; cyc(2);
    chk(ack === 1, "R4 ack held two edges", ack, 1);
    cyc(1);
    chk(ack === 0, "R4 ack drop", ack, 0);
    cyc(4);
    chk(oe === 0 && avail === 0, "R5 floated until need", {oe, avail}, 0);
    need = 1; cyc(1); need = 0;
    chk(oe === 1 && avail === 0, "R5 reclaim drives first", {oe, avail}, 2);
    cyc(1);
    chk(avail === 1, "R5 avail after reclaim", avail, 1);

    // R2 busy defers grant
    busy = 1; hreq = 1; cyc(6);
    chk(ack === 0 && avail === 1, "R2 no grant while busy", {ack, avail}, 1);
    busy = 0; cyc(1);
    chk(ack === 1, "R2 grant when idle", ack, 1);

    // R8 non-enhanced: refresh does not drop ack
    enh = 0; rreq = 1; cyc(1); rreq = 0; cyc(6);
    chk(ack === 1, "R8 ack kept", ack, 1);
    hreq = 0; seen_go = 0;
    for (int i = 0; i < 12; i++) begin cyc(1); if (go) seen_go++; end
    chk(seen_go == 1, "R8 refresh after return", seen_go, 1);

    // R6 enhanced early drop
    enh = 1; hreq = 1; cyc(4);
    chk(ack === 1, "R6 granted", ack, 1);
    rreq = 1; cyc(1); rreq = 0; cyc(1);
    chk(ack === 0 && oe === 0, "R6 ack dropped, still floated", {ack, oe}, 0);
    go_early = 0;
    for (int i = 0; i < 6; i++) begin cyc(1); if (go) go_early++; end
    chk(go_early == 0 && oe === 0, "R7 no refresh while held", go_early, 0);
    hreq = 0; seen_go = 0;
    for (int i = 0; i < 10; i++) begin cyc(1); if (go) seen_go++; end
    chk(seen_go == 1, "R7 refresh after release", seen_go, 1);

    // R9 refresh before grant
    rreq = 1; hreq = 1; cyc(1); rreq = 0; cyc(1);
    chk(go === 1 && ack === 0, "R9 refresh first", {go, ack}, 2);
    cyc(1);
    chk(go === 0 && ack === 1, "R9 single pulse then grant", {go, ack}, 1);
    hreq = 0; cyc(3); need = 1; cyc(2); need = 0;

    // R9 back-to-back requests do not give adjacent pulses
    rreq = 1; cyc(2); rreq = 0; cyc(5);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) enh = $urandom_range(1, 0);
      if ($urandom_range(15, 0) == 0) hreq = ~hreq;
      busy = ($urandom_range(2, 0) == 0);
      need = ($urandom_range(7, 0) == 0);
      rreq = ($urandom_range(39, 0) == 0);
      cyc(1);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); chk(0, "watchdog", 0, 1); end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule